// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block receives asynchronous serial characters on a single line. It does not use a bit-rate clock. It runs on the system clock and uses an enable pulse, `tick_i`, that arrives at sixteen times the bit rate. The line first passes through a two-flop synchroniser. A falling edge starts a tick counter, and the start bit is confirmed by a second look halfway into it. Every following bit is sampled at its centre. The receiver assembles five to eight data bits, least significant first. It then checks the optional parity bit and the first stop bit.

At the centre of the first stop bit the character goes into a holding register, with the unused high bits cleared. The overrun flag is updated in the same cycle. On the next tick the data-available, parity-error and framing-error flags are published. Software, or a neighbouring block, acknowledges the character by pulling `dar_ni` low. Two disable inputs force the data output and the status outputs to zero.

Top module: `uart_rx_top`

## Requirements
- R1: A start is recognised only when the synchronised line is low at a tick after having been seen high at an earlier tick. The start is confirmed only if the line is still low at the 8th tick after detection. If the line is high at that tick, the receiver returns to hunting and loads nothing.
- R2: Data bits are taken least significant bit first, one every 16 ticks after the confirmation. The number of data bits is set by `wlen_i`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: When `par_en_i` is 1, the bit after the data is parity. With `par_even_i`=1 the count of ones in the data plus the parity bit must be even; with `par_even_i`=0 it must be odd. A mismatch sets the parity error flag. When `par_en_i` is 0 the parity error flag is 0.
- R4: The first stop bit is sampled 16 ticks after the previous bit. If it is low, the framing error flag is set for that character.
- R5: The holding register is loaded at the stop-bit sample. Bits at and above the word length read as zero.
- R6: At each load, the overrun flag takes the value data-available had just before that load. It is 1 when the previous character was not yet acknowledged, and 0 otherwise.
- R7: Data-available, parity error and framing error take their new values at the first tick after the load.
- R8: When `dar_ni` is low at a clock edge, data-available clears. Publication at the same edge takes priority over the clear.
- R9: While `stat_off_i` is 1, `da_o`, `oe_o`, `pe_o` and `fe_o` read 0. While `data_off_i` is 1, `rdata_o` reads 0. Internal state is kept in both cases.
- R10: While `rst_ni` is low, the holding register and all flags are zero, and the line is taken as idle (high).
- R11: After a stop bit sampled low, the receiver does not look for a new start until it has seen the line high at a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Enable pulse at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| wlen_i | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| dar_ni | input | 1 | Data-available clear, active low |
| stat_off_i | input | 1 | Forces status outputs to zero |
| data_off_i | input | 1 | Forces data output to zero |
| rdata_o | output | 8 | Holding register contents |
| da_o | output | 1 | Data available |
| oe_o | output | 1 | Overrun error |
| pe_o | output | 1 | Parity error |
| fe_o | output | 1 | Framing error |

## Verification
Several properties assume stable inputs. The assertions on parity and zero-fill assume that `wlen_i`, `par_en_i` and `par_even_i` do not change while a character is being received. They also assume that `tick_i` is a single-cycle pulse, so that a pending publication cannot coincide with a new load. The stimulus meets these assumptions. It changes the format controls only on idle line periods, generates ticks as one-cycle pulses every fourth clock, and drives each line bit for a whole 64-clock bit time. It also adds a start glitch shorter than half a bit and a stop bit held low well past its centre.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  // reset to idle-high so no false start after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pe_o,
  output logic              fe_o
);
  localparam int CNT_W    = $clog2(OVS);
  localparam int BIT_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BIT_W-1:0]   bidx_q;
  logic [DATA_W-1:0]  sh_q;
  logic               acc_q, pe_q, armed_q;
  logic [BIT_W-1:0]   last_bit;
  logic               par_x;

  assign last_bit = BIT_W'(MIN_BITS - 1) + BIT_W'(wlen_i);
  assign par_x    = acc_q ^ line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      pe_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (tick_i) begin
      case (state_q)
        ST_IDLE: begin
          if (armed_q && !line_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          if (line_i) armed_q <= 1'b1;
        end
        ST_START: begin
          if (cnt_q == MID) begin
            cnt_q <= '0;
            if (!line_i) begin
              state_q <= ST_DATA;
              bidx_q  <= '0;
              sh_q    <= '0;
              acc_q   <= 1'b0;
              pe_q    <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: begin
          if (cnt_q == LAST) begin
            cnt_q        <= '0;
            sh_q[bidx_q] <= line_i;
            acc_q        <= acc_q ^ line_i;
            if (bidx_q == last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP;
            else                    bidx_q  <= bidx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PAR: begin
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            pe_q    <= par_even_i ? par_x : ~par_x;
            state_q <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STOP: begin
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            armed_q <= line_i; // a low stop must see high before hunting
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o = tick_i && (state_q == ST_STOP) && (cnt_q == LAST);
  assign data_o = sh_q;
  assign pe_o   = pe_q;
  assign fe_o   = ~line_i;

  p_start_reject_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == MID && line_i) |=> state_q == ST_IDLE);
  p_start_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == MID && !line_i) |=> state_q == ST_DATA);
  p_zero_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> ((data_o >> (MIN_BITS + int'(wlen_i))) == '0));
  p_no_parity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !par_en_i) |-> !pe_o);
  p_hunt_after_low_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !line_i) |=> (state_q == ST_IDLE && !armed_q));
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pe_i,
  input  logic              fe_i,
  input  logic              dar_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              da_o,
  output logic              oe_o,
  output logic              pe_o,
  output logic              fe_o
);
  logic              da_q, oe_q, pe_q, fe_q, pend_q, pe_n_q, fe_n_q;
  logic [DATA_W-1:0] rdata_q;
  logic              publish;

  assign publish = tick_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      da_q    <= 1'b0;
      oe_q    <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      pend_q  <= 1'b0;
      pe_n_q  <= 1'b0;
      fe_n_q  <= 1'b0;
    end else begin
      if (load_i) begin
        rdata_q <= data_i;
        oe_q    <= da_q;
        pe_n_q  <= pe_i;
        fe_n_q  <= fe_i;
        pend_q  <= 1'b1;
      end else if (publish) begin
        da_q   <= 1'b1;
        pe_q   <= pe_n_q;
        fe_q   <= fe_n_q;
        pend_q <= 1'b0;
      end
      if (!dar_ni && !publish) da_q <= 1'b0;
    end
  end

  assign rdata_o = rdata_q;
  assign da_o    = da_q;
  assign oe_o    = oe_q;
  assign pe_o    = pe_q;
  assign fe_o    = fe_q;

  p_publish_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pend_q && !load_i) |=> (da_q && !pend_q));
  p_dar_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dar_ni && !(tick_i && pend_q)) |=> !da_q);
  p_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (oe_q == $past(da_q)));
  p_load_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rdata_q == $past(data_i)));
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              dar_ni,
  input  logic              stat_off_i,
  input  logic              data_off_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              da_o,
  output logic              oe_o,
  output logic              pe_o,
  output logic              fe_o
);
  logic              line;
  logic              load;
  logic [DATA_W-1:0] fr_data, hr_data;
  logic              fr_pe, fr_fe, hr_da, hr_oe, hr_pe, hr_fe;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .line_i    (line),
    .wlen_i    (wlen_i),
    .par_en_i  (par_en_i),
    .par_even_i(par_even_i),
    .load_o    (load),
    .data_o    (fr_data),
    .pe_o      (fr_pe),
    .fe_o      (fr_fe)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (load),
    .data_i (fr_data),
    .pe_i   (fr_pe),
    .fe_i   (fr_fe),
    .dar_ni (dar_ni),
    .rdata_o(hr_data),
    .da_o   (hr_da),
    .oe_o   (hr_oe),
    .pe_o   (hr_pe),
    .fe_o   (hr_fe)
  );

  // disabled outputs read as zero
  assign rdata_o = data_off_i ? '0 : hr_data;
  assign da_o    = hr_da & ~stat_off_i;
  assign oe_o    = hr_oe & ~stat_off_i;
  assign pe_o    = hr_pe & ~stat_off_i;
  assign fe_o    = hr_fe & ~stat_off_i;

  p_stat_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_off_i |-> (da_o == 1'b0 && oe_o == 1'b0 && pe_o == 1'b0 && fe_o == 1'b0));
endmodule

// File: tb/test_uart_rx_top.sv
`timescale 1ns/1ps
module test_uart_rx_top;
  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] wlen = 2'b11;
  logic       par_en = 1'b0, par_even = 1'b0;
  logic       dar_n = 1'b1, stat_off = 1'b0, data_off = 1'b0;
  logic [7:0] rdata;
  logic       da, oe, pe, fe;

  int checks = 0, fails = 0;
  bit done = 0;

  uart_rx_top i_uart_rx_top (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd),
    .wlen_i(wlen), .par_en_i(par_en), .par_even_i(par_even),
    .dar_ni(dar_n), .stat_off_i(stat_off), .data_off_i(data_off),
    .rdata_o(rdata), .da_o(da), .oe_o(oe), .pe_o(pe), .fe_o(fe)
  );

  always #2.5 clk = ~clk;

  int tc = 0;
  always @(negedge clk) begin
    tc = (tc + 1) % TDIV;
    tick <= (tc == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, stepped at every rising edge
  int m_s1 = 1, m_s2 = 1, mst = 0, mcnt = 0, mbit = 0, msh = 0, macc = 0, mpe_f = 0;
  int marmed = 0, m_rd = 0, m_da = 0, m_oe = 0, m_pe = 0, m_fe = 0;
  int m_pend = 0, m_pe_n = 0, m_fe_n = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_s1 = 1; m_s2 = 1; mst = 0; mcnt = 0; mbit = 0; msh = 0; macc = 0; mpe_f = 0;
      marmed = 0; m_rd = 0; m_da = 0; m_oe = 0; m_pe = 0; m_fe = 0;
      m_pend = 0; m_pe_n = 0; m_fe_n = 0;
    end else begin
      int ln, ld, pub, nb, lowstop;
      ln = m_s2; m_s2 = m_s1; m_s1 = int'(rxd);
      ld = 0; lowstop = 0;
      pub = (tick && m_pend != 0) ? 1 : 0;
      nb = 5 + int'(wlen);
      if (tick) begin
        if (mst == 0) begin
          if (marmed != 0 && ln == 0) begin mst = 1; mcnt = 0; end
          if (ln != 0) marmed = 1;
        end else if (mst == 1) begin
          if (mcnt == 7) begin
            mcnt = 0;
            if (ln == 0) begin mst = 2; mbit = 0; msh = 0; macc = 0; mpe_f = 0; end
            else mst = 0;
          end else mcnt++;
        end else if (mcnt == 15) begin
          mcnt = 0;
          if (mst == 2) begin
            msh = msh | (ln << mbit);
            macc = macc ^ ln;
            if (mbit == nb - 1) mst = par_en ? 3 : 4;
            else mbit++;
          end else if (mst == 3) begin
            mpe_f = par_even ? (macc ^ ln) : 1 - (macc ^ ln);
            mst = 4;
          end else begin
            ld = 1; lowstop = (ln == 0) ? 1 : 0; marmed = ln; mst = 0;
          end
        end else mcnt++;
      end
      if (ld != 0) begin
        m_rd = msh; m_oe = m_da; m_pe_n = mpe_f; m_fe_n = lowstop; m_pend = 1;
      end else if (pub != 0) begin
        m_da = 1; m_pe = m_pe_n; m_fe = m_fe_n; m_pend = 0;
      end
      if (!dar_n && pub == 0) m_da = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R5 rdata vs model", int'(rdata), data_off ? 0 : m_rd);
      check("R7 da vs model", int'(da), stat_off ? 0 : m_da);
      check("R6 oe vs model", int'(oe), stat_off ? 0 : m_oe);
      check("R3 pe vs model", int'(pe), stat_off ? 0 : m_pe);
      check("R4 fe vs model", int'(fe), stat_off ? 0 : m_fe);
    end
  end

  task automatic wait_bits(input int n);
    repeat (n * BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                      input int extra_low);
    int nb;
    logic p;
    nb = 5 + int'(wlen);
    rxd = 1'b0; wait_bits(1);
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; p = p ^ d[i]; wait_bits(1);
    end
    if (par_en) begin
      if (!par_even) p = ~p;
      rxd = p ^ bad_par; wait_bits(1);
    end
    rxd = ~bad_stop; wait_bits(1);
    if (bad_stop) wait_bits(extra_low);
    rxd = 1'b1; wait_bits(1);
  endtask

  task automatic ack();
    dar_n = 1'b0; @(negedge clk); dar_n = 1'b1; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10: reset state
    check("R10 rdata in reset", int'(rdata), 0);
    check("R10 da in reset", int'(da), 0);
    check("R10 flags in reset", int'({oe, pe, fe}), 0);
    rst_ni = 1'b1;
    wait_bits(2);

    // R2: 8 bits, no parity, LSB first
    wlen = 2'b11; par_en = 1'b0;
    send(8'hA5, 0, 0, 0);
    check("R2 8-bit data", int'(rdata), 'hA5);
    check("R7 da after load", int'(da), 1);
    check("R3 pe with parity off", int'(pe), 0);
    ack();
    check("R8 da cleared", int'(da), 0);

    // R5: 5 bits, even parity, upper bits zero
    wlen = 2'b00; par_en = 1'b1; par_even = 1'b1;
    send(8'hFF, 0, 0, 0);
    check("R5 zero fill 5-bit", int'(rdata), 'h1F);
    check("R3 even parity ok", int'(pe), 0);
    check("R6 no overrun", int'(oe), 0);
    ack();

    // R3: 6 bits, odd parity, wrong parity bit
    wlen = 2'b01; par_even = 1'b0;
    send(8'h2A, 1, 0, 0);
    check("R2 6-bit data", int'(rdata), 'h2A);
    check("R3 odd parity error", int'(pe), 1);
    ack();
    send(8'h13, 0, 0, 0);
    check("R3 odd parity ok", int'(pe), 0);
    ack();

    // R4 / R11: 7 bits, low stop held low for two more bit times
    wlen = 2'b10; par_en = 1'b0;
    send(8'h55, 0, 1, 2);
    check("R4 framing error", int'(fe), 1);
    check("R5 7-bit data", int'(rdata), 'h55);
    ack();
    wait_bits(6);
    check("R11 no reload after low stop", int'(da), 0);

    // R6: overrun on unacknowledged character
    wlen = 2'b11;
    send(8'h3C, 0, 0, 0);
    check("R4 fe clears on good stop", int'(fe), 0);
    send(8'hC3, 0, 0, 0);
    check("R6 overrun set", int'(oe), 1);
    check("R5 second char kept", int'(rdata), 'hC3);

    // R9: output disables
    stat_off = 1'b1; data_off = 1'b1;
    @(negedge clk);
    check("R9 da gated", int'(da), 0);
    check("R9 oe gated", int'(oe), 0);
    check("R9 data gated", int'(rdata), 0);
    stat_off = 1'b0; data_off = 1'b0;
    @(negedge clk);
    check("R9 da kept", int'(da), 1);
    check("R9 data kept", int'(rdata), 'hC3);
    ack();
    send(8'h81, 0, 0, 0);
    check("R6 overrun cleared", int'(oe), 0);
    ack();

    // R1: start glitch shorter than half a bit
    rxd = 1'b0; repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1; wait_bits(3);
    check("R1 glitch rejected", int'(da), 0);
    check("R1 data unchanged", int'(rdata), 'h81);

    // R8: ack held across a publication, publication wins for that edge
    dar_n = 1'b0;
    send(8'h66, 0, 0, 0);
    check("R8 da cleared while held", int'(da), 0);
    dar_n = 1'b1;
    wait_bits(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule